// File: doc/BRIEF.md
# Debounced External Interrupt Controller

This block takes up to eight input-only lines and turns stable level changes on them into interrupt events. Each line passes through a two-stage synchronizer and then a debounce counter that runs on a one-millisecond tick pulse supplied from outside. A new level is accepted only when it has held across a programmed number of whole tick periods. Each line can be set from 1 to 4000 periods, that is 1 ms to 4 s. A level that lasts less than one period is never accepted.

Each accepted level is compared against a per-line trigger mode. A qualifying event sets a sticky raw status bit. The enabled raw bits are ORed onto a single interrupt output. Firing is single-shot: an edge fires once per accepted change, and a level trigger must be cleared and must see the level go inactive before it can fire again. A clock-gate request tells the clock controller when every enabled line is settled, so the block's clock can be stopped.

Software reaches the block through a small write/read register port. There is one configuration word per line, plus a clear word, a raw status word and a masked status word.

Top module: `eic_debounce_ctrl`

## Requirements
- R1: After reset, every configuration word, the raw status and the masked status read 0, `irq` is 0 and `cg_req` is 1.
- R2: Debounce counting works as follows:
  - For a line with limit N, a level differing from the accepted level is accepted on the (N+1)-th `tick_ms` pulse that the synchronized input spends at the new level. It is not accepted on any earlier pulse.
  - A limit of 0 acts as 1.
- R3: A level that sees at most one `tick_ms` pulse before returning is never accepted and never sets status.
- R4: If the synchronized input returns to the accepted level, the debounce count restarts from zero.
- R5: Trigger field encoding: 00 fires while the accepted level is high, 01 while it is low, 10 on an accepted rise, 11 on an accepted fall. Edge modes set raw status on the same clock edge as the acceptance. Level modes set it one edge later.
- R6: A level trigger fires once. After a clear it stays quiet while the level remains active, and it re-arms only once the accepted level has gone inactive.
- R7: Raw status bits are sticky. Writing address 8 clears each line whose data bit is 1, effective on the write edge. A 0 bit leaves that line unchanged.
- R8: The masked status (address 10) is raw status AND enable. `irq` is the OR of the masked bits.
- R9: A disabled line holds its debounce count at zero, never sets raw status, and starts a fresh count when it is enabled.
- R10: `cg_req` is high only when every enabled line has an idle counter and a settled input matching its accepted level. It drops combinationally on an input change of an enabled line. Disabled lines are ignored.
- R11: Configuration word i lives at address i (0..7), with bits 11:0 holding the limit, 13:12 the trigger mode and 15 the enable. It reads back as written, with bit 14 reading 0. Address 9 reads raw status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| lines_in | input | 8 | External input lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data, combinational from `addr` |
| irq | output | 1 | Combined interrupt |
| cg_req | output | 1 | Clock-gate request, high when idle |

## Verification
An input change reaches the debounce counter two edges after it is driven. From there it needs N+1 tick pulses to be accepted. An edge-mode status bit is visible right after the accepting edge, while a level-mode bit needs one further edge. Clears and configuration writes take effect on their write edge, and `cg_req` follows an input change within the same cycle. The driver therefore waits three idle cycles after every input change and inserts one idle cycle before each level-mode status read. It queues each expectation only at the point where that delay has elapsed, so the monitor compares at the falling edge of the cycle in which the result is due.

// File: rtl/eic_pkg.sv
// Shared types for the debounced interrupt controller.
package eic_pkg;
    // Per-line trigger selection; encoding is visible in the config word.
    typedef enum logic [1:0] {
        TRG_HIGH = 2'b00,
        TRG_LOW  = 2'b01,
        TRG_RISE = 2'b10,
        TRG_FALL = 2'b11
    } trig_e;

    // One-cycle pulses announcing an accepted level change.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/eic_sync.sv
// Two-flop synchronizer for one asynchronous input line.
// Assumes: d may change at any time relative to clk.
// Both stages are exposed so the idle detector can see a change early.
module eic_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic s1,
    output logic s2
);
    // Shift the input through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end
endmodule

// File: rtl/eic_debounce.sv
// Tick-based debounce for one line.
// Counts tick pulses while the synchronized input differs from the accepted
// level and accepts the new level on the pulse after the count reaches the
// limit, so the level has held for at least `limit` whole tick periods.
// Assumes: tick is a single-cycle pulse; a limit of 0 behaves as 1.
module eic_debounce
    import eic_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] limit,
    output logic             level,
    output logic [CNT_W-1:0] cnt,
    output logic             idle,
    output edge_t            ev
);
    logic [CNT_W-1:0] lim_eff;
    logic             differ;
    logic             hit;

    // Resolve the effective limit and the acceptance condition.
    always_comb begin
        lim_eff = (limit == '0) ? CNT_W'(1) : limit;
        differ  = (din != level);
        hit     = en && differ && tick && (cnt == lim_eff);
    end

    // Count ticks while the input differs; accept when the limit is passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
        end else if (!en || !differ) begin
            cnt <= '0;
        end else if (hit) begin
            cnt   <= '0;
            level <= din;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Announce the direction of an accepted change.
    always_comb begin
        ev.rise = hit && din;
        ev.fall = hit && !din;
        idle    = (cnt == '0);
    end
endmodule

// File: rtl/eic_trigger.sv
// Trigger qualification and sticky raw status for one line.
// Edge modes fire on the acceptance pulse; level modes fire once while armed
// and re-arm only after status is cleared and the level has gone inactive.
// Assumes: clr is a single-cycle pulse from the register block.
module eic_trigger
    import eic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  trig_e mode,
    input  logic  level,
    input  edge_t ev,
    input  logic  clr,
    output logic  raw
);
    logic armed;
    logic active;
    logic set;
    logic lvl_mode;

    // Decide whether this cycle produces an event.
    always_comb begin
        lvl_mode = (mode == TRG_HIGH) || (mode == TRG_LOW);
        active   = (mode == TRG_HIGH) ? level : !level;
        unique case (mode)
            TRG_HIGH: set = armed && level;
            TRG_LOW:  set = armed && !level;
            TRG_RISE: set = ev.rise;
            TRG_FALL: set = ev.fall;
            default:  set = 1'b0;
        endcase
        set = set && en;
    end

    // Sticky status: a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw <= 1'b0;
        else if (set)
            raw <= 1'b1;
        else if (clr)
            raw <= 1'b0;
    end

    // Single-shot arming for level modes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (set && lvl_mode)
            armed <= 1'b0;
        else if (!raw && !active)
            armed <= 1'b1;
    end
endmodule

// File: rtl/eic_regs.sv
// Register file: one config word per line, a clear word, raw and masked
// status words. Config: limit in [CNT_W-1:0], mode in [CNT_W+1:CNT_W],
// enable in [CNT_W+3]. Addresses: N_LINES clear, +1 raw, +2 masked.
// Assumes: reads are combinational from addr; writes take effect on the edge.
module eic_regs
    import eic_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int CNT_W   = 12,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [N_LINES-1:0]              raw,
    output logic [N_LINES-1:0]              en,
    output logic [N_LINES-1:0][CNT_W-1:0]   limit,
    output logic [N_LINES-1:0][1:0]         mode,
    output logic [N_LINES-1:0]              clr,
    output logic [DATA_W-1:0]               rdata
);
    localparam int TRIG_LSB = CNT_W;
    localparam int EN_BIT   = CNT_W + 3;
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(N_LINES);
    localparam logic [ADDR_W-1:0] RAW_ADDR = ADDR_W'(N_LINES + 1);
    localparam logic [ADDR_W-1:0] MSK_ADDR = ADDR_W'(N_LINES + 2);

    initial begin
        if (EN_BIT >= DATA_W) $error("config word does not fit DATA_W");
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
        // Capture the config word addressed to this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[i]    <= 1'b0;
                limit[i] <= '0;
                mode[i]  <= 2'b00;
            end else if (wr_en && addr == ADDR_W'(i)) begin
                en[i]    <= wdata[EN_BIT];
                limit[i] <= wdata[CNT_W-1:0];
                mode[i]  <= wdata[TRIG_LSB+1:TRIG_LSB];
            end
        end
    end

    // Write-one-to-clear pulse per line.
    always_comb begin
        clr = (wr_en && addr == CLR_ADDR) ? wdata[N_LINES-1:0] : '0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata[CNT_W-1:0]             = limit[i];
                rdata[TRIG_LSB+1:TRIG_LSB]   = mode[i];
                rdata[EN_BIT]                = en[i];
            end
        end
        if (addr == RAW_ADDR) rdata[N_LINES-1:0] = raw;
        if (addr == MSK_ADDR) rdata[N_LINES-1:0] = raw & en;
    end
endmodule

// File: rtl/eic_debounce_ctrl.sv
// Debounced external interrupt controller, top level.
// Per line: synchronizer, tick debounce, trigger/status. Shared: register
// file, combined interrupt and an idle clock-gate request.
// Assumes: tick_ms is a one-cycle pulse each millisecond from outside;
// the clock gate itself lives outside this block.
module eic_debounce_ctrl
    import eic_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int CNT_W   = 12,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_ms,
    input  logic [N_LINES-1:0] lines_in,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq,
    output logic               cg_req
);
    logic [N_LINES-1:0]            en;
    logic [N_LINES-1:0][CNT_W-1:0] limit;
    logic [N_LINES-1:0][1:0]       mode;
    logic [N_LINES-1:0]            clr;
    logic [N_LINES-1:0]            raw;
    logic [N_LINES-1:0]            acc;
    logic [N_LINES-1:0]            s1;
    logic [N_LINES-1:0]            s2;
    logic [N_LINES-1:0]            idle;
    logic [N_LINES-1:0]            settled;
    logic [N_LINES-1:0][CNT_W-1:0] cnt;

    eic_regs #(
        .N_LINES(N_LINES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .raw(raw), .en(en), .limit(limit), .mode(mode), .clr(clr),
        .rdata(rdata)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        edge_t ev;

        eic_sync u_sync (
            .clk(clk), .rst_n(rst_n), .d(lines_in[i]), .s1(s1[i]), .s2(s2[i])
        );

        eic_debounce #(.CNT_W(CNT_W)) u_deb (
            .clk(clk), .rst_n(rst_n), .en(en[i]), .tick(tick_ms), .din(s2[i]),
            .limit(limit[i]), .level(acc[i]), .cnt(cnt[i]), .idle(idle[i]),
            .ev(ev)
        );

        eic_trigger u_trg (
            .clk(clk), .rst_n(rst_n), .en(en[i]), .mode(trig_e'(mode[i])),
            .level(acc[i]), .ev(ev), .clr(clr[i]), .raw(raw[i])
        );

        // A line is quiet when disabled or fully settled at every stage.
        always_comb begin
            settled[i] = !en[i] || (idle[i] && (s2[i] == acc[i]) &&
                         (s1[i] == s2[i]) && (lines_in[i] == s1[i]));
        end
    end

    // Combined interrupt and idle request.
    always_comb begin
        irq    = |(raw & en);
        cg_req = &settled;
    end
endmodule

// File: rtl/eic_checker.sv
// Property checker for eic_debounce_ctrl, attached by bind.
module eic_checker #(
    parameter int N_LINES = 8,
    parameter int CNT_W   = 12,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            tick_ms,
    input logic [N_LINES-1:0]              lines_in,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               addr,
    input logic [DATA_W-1:0]               wdata,
    input logic                            irq,
    input logic                            cg_req,
    input logic [N_LINES-1:0]              raw,
    input logic [N_LINES-1:0]              en,
    input logic [N_LINES-1:0]              acc,
    input logic [N_LINES-1:0][CNT_W-1:0]   cnt,
    input logic [N_LINES-1:0][CNT_W-1:0]   limit
);
    logic [N_LINES-1:0] clr_req;
    always_comb clr_req = (wr_en && addr == ADDR_W'(N_LINES)) ? wdata[N_LINES-1:0] : '0;

    // R7: a raw bit only falls under a write-one clear.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~raw) & $past(raw) & ~$past(clr_req)) == '0));

    // R9: a disabled line never gains raw status.
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(en)) == '0));

    // R3: the accepted level only moves on a tick.
    p_accept_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != $past(acc)) |-> $past(tick_ms));

    // R8: combined interrupt matches enabled raw status.
    p_irq_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(raw & en));

    // R10: an enabled line whose input disagrees with its level blocks gating.
    p_cg_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (((lines_in ^ acc) & en) != '0) |-> !cg_req);

    for (genvar i = 0; i < N_LINES; i++) begin : g_cnt
        // R2: the debounce count never passes its effective limit.
        p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i] <= ((limit[i] == '0) ? CNT_W'(1) : limit[i]));
    end
endmodule

bind eic_debounce_ctrl eic_checker #(
    .N_LINES(N_LINES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .lines_in(lines_in),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq), .cg_req(cg_req),
    .raw(raw), .en(en), .acc(acc), .cnt(cnt), .limit(limit)
);

// File: tb/sim_eic_debounce_ctrl.sv
module sim_eic_debounce_ctrl;
    localparam int N = 8;
    localparam logic [3:0] A_CLR = 4'd8, A_RAW = 4'd9, A_MSK = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [N-1:0] lines_in = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic        cg_req;

    eic_debounce_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .lines_in(lines_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .cg_req(cg_req)
    );

    always #4 clk = ~clk;

    // kind: 0 = rdata, 1 = irq, 2 = cg_req
    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Monitor: compare queued expectations away from the active edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = rdata;
                1: act = {15'd0, irq};
                default: act = {15'd0, cg_req};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h (kind %0d)", it.req, act, it.exp, it.kind);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk) #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(posedge clk) #1;
            tick_ms = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk) #1;
        wr_en = 1'b0;
    endtask

    // Driver: set up the observation and push the expected value.
    task automatic expect_rd(input logic [3:0] a, input logic [15:0] e, input string r);
        item_t it;
        addr = a;
        it.kind = 0; it.exp = e; it.req = r;
        q.push_back(it);
        @(posedge clk) #1;
    endtask

    task automatic expect_bit(input int k, input logic e, input string r);
        item_t it;
        it.kind = k; it.exp = {15'd0, e}; it.req = r;
        q.push_back(it);
        @(posedge clk) #1;
    endtask

    task automatic set_line(input int i, input logic v);
        lines_in[i] = v;
        step(3);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
            report();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_rd(A_RAW, 16'h0, "R1 raw");
        expect_rd(A_MSK, 16'h0, "R1 masked");
        expect_rd(4'd0, 16'h0, "R1 config");
        expect_bit(1, 1'b0, "R1 irq");
        expect_bit(2, 1'b1, "R1 cg_req");

        // R11 line 0: enable, rise, limit 2
        wr(4'd0, 16'hA002);
        expect_rd(4'd0, 16'hA002, "R11 readback");
        wr(4'd5, 16'h7FFF);
        expect_rd(4'd5, 16'h3FFF, "R11 bit14 reads 0");
        wr(4'd5, 16'h0000);

        // R10 combinational drop, R2 acceptance on third tick
        lines_in[0] = 1'b1;
        expect_bit(2, 1'b0, "R10 drop on input change");
        step(2);
        ticks(2);
        expect_rd(A_RAW, 16'h0, "R2 not accepted after N ticks");
        expect_bit(2, 1'b0, "R10 low while debouncing");
        ticks(1);
        expect_rd(A_RAW, 16'h1, "R2 R5 rise accepted on N+1 tick");
        expect_bit(2, 1'b1, "R10 high when settled");
        expect_rd(A_MSK, 16'h1, "R8 masked");
        expect_bit(1, 1'b1, "R8 irq");

        // R7 clear
        wr(A_CLR, 16'h0000);
        expect_rd(A_RAW, 16'h1, "R7 zero write keeps bit");
        wr(A_CLR, 16'h0001);
        expect_rd(A_RAW, 16'h0, "R7 clear");
        expect_bit(1, 1'b0, "R7 irq after clear");

        // R3 line 1: high level, limit 1
        wr(4'd1, 16'h8001);
        lines_in[1] = 1'b1;
        step(1);
        set_line(1, 1'b0);
        ticks(3);
        step(1);
        expect_rd(A_RAW, 16'h0, "R3 pulse without tick");
        set_line(1, 1'b1);
        ticks(1);
        set_line(1, 1'b0);
        ticks(2);
        step(1);
        expect_rd(A_RAW, 16'h0, "R3 pulse across one tick");

        // R4 restart
        set_line(1, 1'b1);
        ticks(1);
        set_line(1, 1'b0);
        set_line(1, 1'b1);
        ticks(1);
        step(1);
        expect_rd(A_RAW, 16'h0, "R4 count restarted");
        ticks(1);
        step(1);
        expect_rd(A_RAW, 16'h2, "R4 accepted after restart");

        // R6 single-shot level
        wr(A_CLR, 16'h0002);
        step(2);
        expect_rd(A_RAW, 16'h0, "R6 no refire while held");
        set_line(1, 1'b0);
        ticks(2);
        set_line(1, 1'b1);
        ticks(2);
        step(1);
        expect_rd(A_RAW, 16'h2, "R6 refire after re-arm");
        wr(A_CLR, 16'h0002);

        // R5 low level on line 2
        wr(4'd2, 16'h9001);
        step(1);
        expect_rd(A_RAW, 16'h4, "R5 low level fires");
        wr(A_CLR, 16'h0004);
        step(1);
        expect_rd(A_RAW, 16'h0, "R6 low level stays quiet");

        // R5 fall on line 3
        wr(4'd3, 16'hB001);
        set_line(3, 1'b1);
        ticks(2);
        step(1);
        expect_rd(A_RAW, 16'h0, "R5 fall ignores rise");
        set_line(3, 1'b0);
        ticks(2);
        expect_rd(A_RAW, 16'h8, "R5 fall fires");
        wr(A_CLR, 16'h0008);

        // R9 disabled line 4
        wr(4'd4, 16'h0001);
        set_line(4, 1'b1);
        ticks(3);
        step(1);
        expect_rd(A_RAW, 16'h0, "R9 disabled no status");
        expect_bit(2, 1'b1, "R10 disabled line ignored");
        wr(4'd4, 16'h8001);
        expect_bit(2, 1'b0, "R10 enabled mismatch blocks");
        ticks(1);
        step(1);
        expect_rd(A_RAW, 16'h0, "R9 fresh count after enable");
        ticks(1);
        step(1);
        expect_rd(A_RAW, 16'h10, "R9 accepted after enable");
        wr(4'd4, 16'h0001);
        expect_rd(A_MSK, 16'h0, "R8 masked hides disabled");
        expect_rd(A_RAW, 16'h10, "R8 raw kept when disabled");
        expect_bit(1, 1'b0, "R8 irq masked");

        step(3);
        done = 1'b1;
        report();
    end
endmodule